// File: doc/BRIEF.md
# TDM Serial Channel Port

This block terminates one serial line pair of a time-division-multiplexed frame. The frame holds 32 channel slots of eight bits each, 256 bit periods in all, and an active-low frame pulse marks where each frame starts. The port counts bit periods from that pulse. On the receive line it assembles each byte of a small active group of channels (channels 0 to 4) and hands it to the host as parallel data tagged with its channel number. On the transmit line it serializes one host-supplied byte for each active channel and tri-states the line in every other slot.

The port runs directly from the serial clock. A static select input sets the rate. In single-rate mode each bit lasts one clock, and the frame pulse is taken on the rising edge. In double-rate mode each bit lasts two clocks, and the frame pulse is taken on the falling edge. The host loads transmit bytes through a simple write port. The port reports a framing error whenever a frame pulse arrives anywhere other than at the frame boundary it expects, and it then realigns to that pulse.

Top module: `tdm_chan_port`

## Requirements
- R1: A frame is 256 bit periods (32 channels of 8 bits), and channel 31 bit 0 is followed directly by channel 0 bit 7. When a frame pulse is taken, the bit period that follows is channel 0, bit 7.
- R2: Bytes are carried most significant bit first on both lines: bit 7 is in the first bit period of a slot and bit 0 in the last.
- R3: After the last bit of an active channel (0 to 4) is received, `rx_valid` is high for exactly one clock. During that clock `rx_data` holds the byte (first received bit in bit 7) and `rx_ch` holds the channel number.
- R4: Channels 5 to 31 are ignored: no `rx_valid` strobe is produced for them.
- R5: While the port is locked, `sdo_oe` is high and `sdo` is driven during the slots of channels 0 to 4 only. At all other times `sdo` is high impedance and `sdo_oe` is low. An enabled window always starts at bit 7 of a slot.
- R6: A write with `tx_we` high and `tx_sel` from 0 to 4 stores `tx_wdata` as the transmit byte of that channel. Each byte is copied at the start of its channel's slot, using the value held just before that clock edge. Writes with `tx_sel` 5 to 7 have no effect.
- R7: With `rate_sel`=0, a bit lasts one clock, the frame pulse is sampled on the rising edge, and `sdi` is sampled on the rising edge that ends the bit. With `rate_sel`=1, a bit lasts two clocks, the frame pulse is sampled on the falling edge, `sdo` changes only at the start of a bit, and `sdi` is sampled on the rising edge between the bit's two clocks.
- R8: While locked, a frame pulse taken anywhere other than at the last clock of a frame raises `frame_err` for one clock, and counting restarts from that pulse.
- R9: After reset the port is unlocked: `sdo_oe`, `rx_valid` and `frame_err` are low. The first frame pulse locks the port without raising `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, single or double bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | Static rate select: 0 one clock per bit, 1 two clocks per bit |
| fp_n | input | 1 | Active-low frame pulse |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data, high impedance outside active slots |
| sdo_oe | output | 1 | High while `sdo` is driven |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_sel | input | 3 | Channel selected for the write |
| tx_wdata | input | 8 | Transmit byte to store |
| rx_valid | output | 1 | One-clock strobe for a received byte |
| rx_ch | output | 3 | Channel number of the received byte |
| rx_data | output | 8 | Received byte |
| frame_err | output | 1 | One-clock strobe for a misplaced frame pulse |

## Verification
The bench drives both clock rates and starts the first pulse at an arbitrary offset. A port that flagged the locking pulse as an error, or enabled `sdo` before it locked, would be caught. It injects a pulse early in the frame and checks both the single error strobe and the realigned counting. A port that kept its old alignment would shift every later byte and strobe and miscompare from then on. Random host writes, including writes to the unused select codes, land next to slot boundaries. A port that copied the new value a clock early, or accepted writes to codes 5 to 7, would put wrong bits on `sdo`. In double-rate mode the reference samples `sdi` mid-bit, so a port that sampled on the wrong clock of the pair would return shifted bytes.

// File: rtl/tdm_chan_port.sv
module tdm_chan_port #(
  parameter int CHANS  = 32,
  parameter int BITS   = 8,
  parameter int ACTIVE = 5,
  localparam int SLOT_W = $clog2(BITS),
  localparam int CH_W   = $clog2(CHANS),
  localparam int CNT_W  = SLOT_W + CH_W,
  localparam int SEL_W  = $clog2(ACTIVE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_sel,
  input  logic             fp_n,
  input  logic             sdi,
  output wire              sdo,
  output logic             sdo_oe,
  input  logic             tx_we,
  input  logic [SEL_W-1:0] tx_sel,
  input  logic [BITS-1:0]  tx_wdata,
  output logic             rx_valid,
  output logic [SEL_W-1:0] rx_ch,
  output logic [BITS-1:0]  rx_data,
  output logic             frame_err
);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             phase, phase_nx;
  logic             locked;
  logic             fp_neg;
  logic [BITS-1:0]  tx_sh, rx_sh;
  logic [BITS-1:0]  tx_reg [ACTIVE];

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fp_neg <= 1'b1;
    else        fp_neg <= fp_n;

  wire             fp_hit  = ~(rate_sel ? fp_neg : fp_n);
  wire             step    = ~rate_sel | phase;
  wire             smp     = ~rate_sel | ~phase;
  wire [CH_W-1:0]  chan    = cnt[CNT_W-1:SLOT_W];
  wire [CH_W-1:0]  chan_nx = cnt_nx[CNT_W-1:SLOT_W];
  wire             active  = int'(chan) < ACTIVE;
  wire             last_b  = cnt[SLOT_W-1:0] == SLOT_W'(BITS-1);
  wire             on_time = (cnt == '1) & step;
  wire             load    = (fp_hit | step) & (cnt_nx[SLOT_W-1:0] == '0)
                             & (int'(chan_nx) < ACTIVE);

  always_comb begin
    cnt_nx   = cnt;
    phase_nx = 1'b0;
    if (fp_hit) begin
      cnt_nx = '0;
    end else begin
      if (step) cnt_nx = cnt + 1'b1;
      phase_nx = rate_sel & ~phase;
    end
  end

  assign sdo_oe = locked & active;
  assign sdo    = sdo_oe ? tx_sh[BITS-1] : 1'bz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      phase     <= 1'b0;
      locked    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      cnt       <= cnt_nx;
      phase     <= phase_nx;
      locked    <= locked | fp_hit;
      frame_err <= locked & fp_hit & ~on_time;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < ACTIVE; i++) tx_reg[i] <= '0;
    end else if (tx_we && int'(tx_sel) < ACTIVE) begin
      tx_reg[tx_sel] <= tx_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     tx_sh <= '0;
    else if (load)  tx_sh <= tx_reg[chan_nx[SEL_W-1:0]];
    else if (step)  tx_sh <= {tx_sh[BITS-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_ch    <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (smp) begin
        rx_sh <= {rx_sh[BITS-2:0], sdi};
        if (locked && active && last_b) begin
          rx_valid <= 1'b1;
          rx_data  <= {rx_sh[BITS-2:0], sdi};
          rx_ch    <= chan[SEL_W-1:0];
        end
      end
    end

endmodule

// File: rtl/tdm_chan_port_chk.sv
module tdm_chan_port_chk #(
  parameter int ACTIVE = 5,
  parameter int SEL_W  = 3,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_sel,
  input logic             fp_n,
  input logic             sdo_oe,
  input logic             rx_valid,
  input logic [SEL_W-1:0] rx_ch,
  input logic             frame_err,
  input logic             locked,
  input logic             phase,
  input logic [CNT_W-1:0] cnt
);

  assert_rx_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_rx_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> int'(rx_ch) < ACTIVE);

  assert_slot_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (cnt[SLOT_W-1:0] == '0) && !phase);

  assert_mid_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel && rx_valid && cnt != '0) |-> phase);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_sel && frame_err) |-> $past(!fp_n));

  assert_unlocked_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sdo_oe && !rx_valid && !frame_err);

endmodule

bind tdm_chan_port tdm_chan_port_chk #(
  .ACTIVE(ACTIVE), .SEL_W(SEL_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fp_n(fp_n),
  .sdo_oe(sdo_oe), .rx_valid(rx_valid), .rx_ch(rx_ch),
  .frame_err(frame_err), .locked(locked), .phase(phase), .cnt(cnt)
);

// File: tb/tdm_chan_port_test.sv
`timescale 1ns/1ps
module tdm_chan_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_sel = 1'b0;
  logic       fp_n = 1'b1;
  logic       sdi = 1'b0;
  wire        sdo;
  logic       sdo_oe;
  logic       tx_we = 1'b0;
  logic [2:0] tx_sel = '0;
  logic [7:0] tx_wdata = '0;
  logic       rx_valid;
  logic [2:0] rx_ch;
  logic [7:0] rx_data;
  logic       frame_err;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  tdm_chan_port uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fp_n(fp_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .tx_we(tx_we), .tx_sel(tx_sel),
    .tx_wdata(tx_wdata), .rx_valid(rx_valid), .rx_ch(rx_ch),
    .rx_data(rx_data), .frame_err(frame_err)
  );

  // behavioural reference: bit position in frame, half-bit phase, slot byte
  int         m_pos, m_ph;
  bit         m_lock;
  logic [7:0] m_tx [5];
  logic [7:0] m_byte, m_rx;
  bit         e_val, e_err;
  logic [7:0] e_data;
  int         e_ch;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_ph = 0; m_lock = 0; m_byte = '0; m_rx = '0;
      e_val = 0; e_err = 0; e_data = '0; e_ch = 0;
      for (int i = 0; i < 5; i++) m_tx[i] = '0;
    end else begin
      bit pulse, smp, stp;
      pulse = !fp_n;
      smp   = !rate_sel || m_ph == 0;
      stp   = !rate_sel || m_ph == 1;
      e_err = m_lock && pulse && !(m_pos == 255 && stp);
      e_val = 0;
      if (smp) begin
        m_rx = {m_rx[6:0], sdi};
        if (m_lock && m_pos / 8 < 5 && m_pos % 8 == 7) begin
          e_val = 1; e_data = m_rx; e_ch = m_pos / 8;
        end
      end
      if (pulse) begin
        m_pos = 0; m_ph = 0;
      end else begin
        if (stp) m_pos = (m_pos + 1) % 256;
        m_ph = rate_sel ? 1 - m_ph : 0;
      end
      if ((pulse || stp) && m_pos % 8 == 0 && m_pos / 8 < 5) m_byte = m_tx[m_pos / 8];
      if (tx_we && tx_sel < 5) m_tx[tx_sel] = tx_wdata;
      if (pulse) m_lock = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      vectors++;
      if (sdo_oe || rx_valid || frame_err) begin
        miscompares++;
        $display("FAIL R9 reset state: oe=%0b valid=%0b err=%0b expected 0 0 0",
                 sdo_oe, rx_valid, frame_err);
      end
    end else begin
      bit e_oe;
      vectors++;
      e_oe = m_lock && m_pos / 8 < 5;
      if (sdo_oe !== e_oe) begin
        miscompares++;
        $display("FAIL R5 sdo_oe at pos %0d: got %b expected %b", m_pos, sdo_oe, e_oe);
      end else if (e_oe && sdo !== m_byte[7 - m_pos % 8]) begin
        miscompares++;
        $display("FAIL R1 R2 R6 R7 sdo at pos %0d: got %b expected %b",
                 m_pos, sdo, m_byte[7 - m_pos % 8]);
      end
      if (rx_valid !== e_val) begin
        miscompares++;
        $display("FAIL R3 R4 R7 rx_valid: got %b expected %b", rx_valid, e_val);
      end else if (e_val && (rx_data !== e_data || int'(rx_ch) != e_ch)) begin
        miscompares++;
        $display("FAIL R3 R2 rx byte: got ch%0d %h expected ch%0d %h",
                 rx_ch, rx_data, e_ch, e_data);
      end
      if (frame_err !== e_err) begin
        miscompares++;
        $display("FAIL R8 R9 frame_err: got %b expected %b", frame_err, e_err);
      end
    end
  end

  task automatic run(input int ncyc, input int first, input int period);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #2;
      fp_n     = !(i >= first && (i - first) % period == 0);
      sdi      = 1'($urandom);
      tx_we    = ($urandom % 8) == 0;
      tx_sel   = 3'($urandom);
      tx_wdata = 8'($urandom);
    end
  endtask

  task automatic do_reset(input logic rate);
    @(posedge clk); #2;
    rst_n = 1'b0; rate_sel = rate; fp_n = 1'b1; tx_we = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    do_reset(1'b0);
    run(40, 1000, 1000);    // R9: unlocked idle
    run(900, 37, 256);      // R1 R9: lock, aligned frames
    run(700, 100, 256);     // R8: early pulse, then realigned
    run(300, 1000, 1000);
    do_reset(1'b1);
    run(1600, 11, 512);     // R7: double rate
    run(1200, 77, 512);     // R8: misplaced pulse in double rate
    run(400, 1000, 1000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule